// File: doc/BRIEF.md
# Silicon Strip Cluster Preprocessor

This block cleans and clusters a stream of silicon strip samples. Each sample carries a strip address, the identifier of the readout chip that produced it and a raw pulse height. A strip flagged in a per-strip dead-strip mask is forced to zero. Every other strip is corrected with the pedestal and gain of its chip: the pedestal is subtracted, the result is scaled by the gain, and the amplitude is clamped at zero. Runs of neighbouring strips above a programmable threshold are gathered into clusters. For each cluster the block reports a pulse-height weighted centroid over five strips centred on the cluster peak, together with the summed cluster charge.

Samples arrive over a valid/ready handshake. A sample flagged as end-of-event closes any open cluster and is passed to the output as a separate one-cycle strobe. A register write port loads the mask bits, the per-chip pedestals and gains, and the threshold. The first stage registers the corrected amplitude. The second stage is a three-state machine. From `ST_IDLE`, a strip above threshold moves it to `ST_OPEN`, and an end-of-event marker is echoed while it stays in `ST_IDLE`. From `ST_OPEN`, a contiguous strip above threshold keeps it in `ST_OPEN`, a non-contiguous strip above threshold emits the cluster and restarts in `ST_OPEN`, and a strip at or below threshold emits the cluster and returns to `ST_IDLE`. An end-of-event marker in `ST_OPEN` emits the cluster and moves it to `ST_EOE`. From `ST_EOE` it always returns to `ST_IDLE` after echoing the marker.

Top module: `strip_cluster_pre`

## Requirements
- R1: A strip whose mask bit is set (written with `cfg_kind`=0, `cfg_idx`=strip, `cfg_wdata[0]`=1) gets amplitude 0 before threshold, clustering and centroid.
- R2: The corrected amplitude is ((raw − ped[chip]) × gain[chip]) >> 8. It is 0 when raw ≤ ped and saturates at 4095. Pedestals are written with `cfg_kind`=1 and gains with `cfg_kind`=2, indexed by `cfg_idx[1:0]` = chip.
- R3: A strip joins or opens a cluster only if its amplitude is strictly greater than the threshold (written with `cfg_kind`=3).
- R4: A cluster closes at the first strip whose amplitude is at or below threshold, or whose address is not the previous address plus one. Strip 0 never continues a cluster that ends at strip 63.
- R5: `out_charge` is the sum of the amplitudes of the cluster's strips, saturating at 65535.
- R6: The centroid window is the five strips centred on the first strip of maximal amplitude in the cluster. Window positions outside the cluster (including positions beyond the sensor edge) count as zero.
- R7: `out_centroid` = peak×16 + trunc(16×(2(a₊₂−a₋₂) + (a₊₁−a₋₁)) / Σa), with truncation toward zero. This gives a strip index with 4 fractional bits.
- R8: An end-of-event marker produces a one-cycle `out_eoe`, never in the same cycle as `out_valid`. If a cluster is open, the cluster is emitted first and `out_eoe` follows in the next cycle.
- R9: While an end-of-event marker is waiting behind a flushed cluster, `in_ready` drops if a sample is queued. No sample is lost or reordered.
- R10: After reset, `out_valid`, `out_eoe` are 0 and `in_ready` is 1. All mask bits are clear, pedestals are 0, gains are 256 (unity) and the threshold is 0.
- R11: A cluster output appears two cycles after the edge that accepts the closing sample. That is one register stage for correction and one for the state machine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Target: 0 mask, 1 pedestal, 2 gain, 3 threshold |
| cfg_idx | input | 6 | Strip index (mask) or chip index in low bits |
| cfg_wdata | input | 12 | Write value |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample accepted when high with `in_valid` |
| in_eoe | input | 1 | Sample is an end-of-event marker |
| in_addr | input | 6 | Strip address |
| in_chip | input | 2 | Readout chip |
| in_raw | input | 12 | Raw pulse height |
| out_valid | output | 1 | Cluster strobe |
| out_centroid | output | 10 | Centroid, strip index with 4 fractional bits |
| out_charge | output | 16 | Summed cluster charge |
| out_eoe | output | 1 | End-of-event strobe |

## Verification
The hardest condition to reach is the input stall. It occurs only when an end-of-event marker arrives while a cluster is open and a further sample is already queued in the first stage. The stimulus streams samples back to back with no idle cycles, so every event that ends with an open cluster drives the block into this state. The bench counts the stalled cycles and compares the full output order against the expected list. Address wraparound at the sensor edge, a masked strip splitting a run, and a tie between two peak strips each have their own event in the table.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [1:0] {
        CFG_MASK = 2'd0,
        CFG_PED  = 2'd1,
        CFG_GAIN = 2'd2,
        CFG_THR  = 2'd3
    } cfg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_EOE  = 2'd2
    } clu_state_e;

endpackage

// File: rtl/scp_calib.sv
module scp_calib #(
    parameter int ADDR_W = 6,
    parameter int CHIP_W = 2,
    parameter int AMP_W  = 12,
    parameter int GAIN_W = 10,
    parameter int FRAC   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [ADDR_W-1:0] cfg_idx,
    input  logic [AMP_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_eoe,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CHIP_W-1:0] in_chip,
    input  logic [AMP_W-1:0]  in_raw,
    input  logic              s2_ready,
    output logic              s1_valid,
    output logic              s1_eoe,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [AMP_W-1:0]  s1_amp,
    output logic [AMP_W-1:0]  thr
);
    import scp_pkg::*;

    localparam int NSTRIP  = 2 ** ADDR_W;
    localparam int NCHIP   = 2 ** CHIP_W;
    localparam int PW      = AMP_W + GAIN_W;
    localparam int SW      = PW - FRAC;
    localparam int AMP_MAX = (1 << AMP_W) - 1;
    localparam int UNITY   = 1 << FRAC;

    logic [NSTRIP-1:0] mask_q;
    logic [AMP_W-1:0]  ped_q  [NCHIP];
    logic [GAIN_W-1:0] gain_q [NCHIP];
    logic [AMP_W-1:0]  thr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            thr_q  <= '0;
            for (int c = 0; c < NCHIP; c++) begin
                ped_q[c]  <= '0;
                gain_q[c] <= GAIN_W'(UNITY);
            end
        end else if (cfg_we) begin
            unique case (cfg_kind_e'(cfg_kind))
                CFG_MASK: mask_q[cfg_idx]          <= cfg_wdata[0];
                CFG_PED:  ped_q[cfg_idx[CHIP_W-1:0]]  <= cfg_wdata;
                CFG_GAIN: gain_q[cfg_idx[CHIP_W-1:0]] <= cfg_wdata[GAIN_W-1:0];
                CFG_THR:  thr_q                    <= cfg_wdata;
                default:  ;
            endcase
        end
    end

    assign thr = thr_q;

    logic [AMP_W:0]   diff;
    logic [PW-1:0]    prod;
    logic [SW-1:0]    scaled;
    logic [AMP_W-1:0] corr;

    always_comb begin
        diff   = {1'b0, in_raw} - {1'b0, ped_q[in_chip]};
        prod   = PW'(diff[AMP_W-1:0]) * PW'(gain_q[in_chip]);
        scaled = SW'(prod >> FRAC);
        if (mask_q[in_addr] || diff[AMP_W] || (diff == '0))
            corr = '0;
        else if (scaled > SW'(AMP_MAX))
            corr = AMP_W'(AMP_MAX);
        else
            corr = scaled[AMP_W-1:0];
    end

    assign in_ready = !s1_valid || s2_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_eoe   <= 1'b0;
            s1_addr  <= '0;
            s1_amp   <= '0;
        end else if (in_ready) begin
            s1_valid <= in_valid;
            s1_eoe   <= in_eoe;
            s1_addr  <= in_addr;
            s1_amp   <= corr;
        end
    end

    p_mask_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_eoe && mask_q[in_addr]) |=> (s1_amp == '0));

    p_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_eoe && (in_raw <= ped_q[in_chip])) |=> (s1_amp == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s2_ready) |=> (s1_valid && $stable(s1_addr) && $stable(s1_amp) && $stable(s1_eoe)));

endmodule

// File: rtl/scp_centroid.sv
module scp_centroid #(
    parameter int ADDR_W = 6,
    parameter int AMP_W  = 12
) (
    input  logic [ADDR_W-1:0]   peak_addr,
    input  logic [AMP_W-1:0]    a_m2,
    input  logic [AMP_W-1:0]    a_m1,
    input  logic [AMP_W-1:0]    a_pk,
    input  logic [AMP_W-1:0]    a_p1,
    input  logic [AMP_W-1:0]    a_p2,
    output logic [ADDR_W+3:0]   centroid
);
    localparam int MW = AMP_W + 4;
    localparam int NW = MW + 4;
    localparam int CW = ADDR_W + 4;

    logic        [AMP_W+2:0] sum5;
    logic signed [MW-1:0]    d2, d1, mom;
    logic signed [NW-1:0]    num, quo;
    logic        [CW-1:0]    base;

    always_comb begin
        sum5 = (AMP_W+3)'(a_m2) + (AMP_W+3)'(a_m1) + (AMP_W+3)'(a_pk)
             + (AMP_W+3)'(a_p1) + (AMP_W+3)'(a_p2);
        d2   = MW'(a_p2) - MW'(a_m2);
        d1   = MW'(a_p1) - MW'(a_m1);
        mom  = (d2 <<< 1) + d1;
        num  = NW'(mom) <<< 4;
        if (sum5 == '0)
            quo = '0;
        else
            quo = num / $signed(NW'(sum5));
        base     = {peak_addr, 4'b0000};
        centroid = base + CW'(quo);
    end

endmodule

// File: rtl/scp_cluster_fsm.sv
module scp_cluster_fsm #(
    parameter int ADDR_W = 6,
    parameter int AMP_W  = 12,
    parameter int CHG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic              s1_eoe,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic [AMP_W-1:0]  s1_amp,
    input  logic [AMP_W-1:0]  thr,
    output logic              s2_ready,
    output logic              out_valid,
    output logic [ADDR_W+3:0] out_centroid,
    output logic [CHG_W-1:0]  out_charge,
    output logic              out_eoe
);
    import scp_pkg::*;

    clu_state_e state_q, state_d;

    logic [ADDR_W-1:0] last_q, paddr_q;
    logic [AMP_W-1:0]  peak_q, pm1_q, pm2_q, pp1_q, pp2_q, h1_q, h2_q;
    logic [1:0]        after_q;
    logic [CHG_W-1:0]  charge_q;
    logic [ADDR_W+3:0] cent;

    logic take, above, contig, is_open, close_clu, start_clu, extend_clu;
    logic [CHG_W:0] csum;

    assign s2_ready = (state_q != ST_EOE);
    assign take     = s1_valid && s2_ready;
    assign above    = (s1_amp > thr);
    assign contig   = ({1'b0, s1_addr} == ({1'b0, last_q} + 1'b1));
    assign is_open  = (state_q == ST_OPEN);

    assign close_clu  = take && is_open && (s1_eoe || !above || !contig);
    assign start_clu  = take && !s1_eoe && above && (!is_open || !contig);
    assign extend_clu = take && !s1_eoe && above && is_open && contig;
    assign csum       = {1'b0, charge_q} + (CHG_W+1)'(s1_amp);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take && !s1_eoe && above) state_d = ST_OPEN;
            ST_OPEN: if (take) begin
                if (s1_eoe)      state_d = ST_EOE;
                else if (!above) state_d = ST_IDLE;
                else             state_d = ST_OPEN;
            end
            ST_EOE:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0; paddr_q <= '0; peak_q <= '0;
            pm1_q <= '0; pm2_q <= '0; pp1_q <= '0; pp2_q <= '0;
            h1_q <= '0; h2_q <= '0; after_q <= '0; charge_q <= '0;
        end else if (start_clu) begin
            last_q   <= s1_addr;
            paddr_q  <= s1_addr;
            peak_q   <= s1_amp;
            pm1_q    <= '0; pm2_q <= '0; pp1_q <= '0; pp2_q <= '0;
            h1_q     <= s1_amp;
            h2_q     <= '0;
            after_q  <= '0;
            charge_q <= CHG_W'(s1_amp);
        end else if (extend_clu) begin
            last_q   <= s1_addr;
            h1_q     <= s1_amp;
            h2_q     <= h1_q;
            charge_q <= csum[CHG_W] ? '1 : csum[CHG_W-1:0];
            if (s1_amp > peak_q) begin
                peak_q  <= s1_amp;
                paddr_q <= s1_addr;
                pm1_q   <= h1_q;
                pm2_q   <= h2_q;
                pp1_q   <= '0;
                pp2_q   <= '0;
                after_q <= '0;
            end else if (after_q == 2'd0) begin
                pp1_q   <= s1_amp;
                after_q <= 2'd1;
            end else if (after_q == 2'd1) begin
                pp2_q   <= s1_amp;
                after_q <= 2'd2;
            end
        end
    end

    scp_centroid #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_cent (
        .peak_addr (paddr_q),
        .a_m2      (pm2_q),
        .a_m1      (pm1_q),
        .a_pk      (peak_q),
        .a_p1      (pp1_q),
        .a_p2      (pp2_q),
        .centroid  (cent)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_centroid <= '0;
            out_charge   <= '0;
            out_eoe      <= 1'b0;
        end else begin
            out_valid <= close_clu;
            if (close_clu) begin
                out_centroid <= cent;
                out_charge   <= charge_q;
            end
            out_eoe <= (state_q == ST_EOE) || (take && s1_eoe && (state_q == ST_IDLE));
        end
    end

    p_eoe_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_eoe |-> !out_valid);

    p_flush_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && s1_eoe && is_open) |=> out_valid ##1 out_eoe);

    p_charge_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_charge != '0));

    p_open_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !s1_eoe && !above) |=> (state_q != ST_OPEN));

endmodule

// File: rtl/strip_cluster_pre.sv
module strip_cluster_pre #(
    parameter int ADDR_W = 6,
    parameter int CHIP_W = 2,
    parameter int AMP_W  = 12,
    parameter int GAIN_W = 10,
    parameter int FRAC   = 8,
    parameter int CHG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [ADDR_W-1:0] cfg_idx,
    input  logic [AMP_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_eoe,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CHIP_W-1:0] in_chip,
    input  logic [AMP_W-1:0]  in_raw,
    output logic              out_valid,
    output logic [ADDR_W+3:0] out_centroid,
    output logic [CHG_W-1:0]  out_charge,
    output logic              out_eoe
);
    logic              s1_valid, s1_eoe, s2_ready;
    logic [ADDR_W-1:0] s1_addr;
    logic [AMP_W-1:0]  s1_amp, thr;

    scp_calib #(
        .ADDR_W(ADDR_W), .CHIP_W(CHIP_W), .AMP_W(AMP_W),
        .GAIN_W(GAIN_W), .FRAC(FRAC)
    ) u_calib (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_eoe(in_eoe),
        .in_addr(in_addr), .in_chip(in_chip), .in_raw(in_raw),
        .s2_ready(s2_ready),
        .s1_valid(s1_valid), .s1_eoe(s1_eoe), .s1_addr(s1_addr), .s1_amp(s1_amp),
        .thr(thr)
    );

    scp_cluster_fsm #(.ADDR_W(ADDR_W), .AMP_W(AMP_W), .CHG_W(CHG_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_eoe(s1_eoe), .s1_addr(s1_addr), .s1_amp(s1_amp),
        .thr(thr), .s2_ready(s2_ready),
        .out_valid(out_valid), .out_centroid(out_centroid),
        .out_charge(out_charge), .out_eoe(out_eoe)
    );

    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s1_valid));

endmodule

// File: tb/strip_cluster_pre_tb.sv
module strip_cluster_pre_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSTIM = 37;
    localparam int NEXP  = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [5:0]  cfg_idx = '0;
    logic [11:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_eoe = 1'b0;
    logic [5:0]  in_addr = '0;
    logic [1:0]  in_chip = '0;
    logic [11:0] in_raw = '0;
    logic        out_valid, out_eoe;
    logic [9:0]  out_centroid;
    logic [15:0] out_charge;

    int tests = 0, fails = 0, stalls = 0, n_got = 0;
    bit done = 0;
    logic [26:0] got [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    strip_cluster_pre u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_eoe(in_eoe),
        .in_addr(in_addr), .in_chip(in_chip), .in_raw(in_raw),
        .out_valid(out_valid), .out_centroid(out_centroid),
        .out_charge(out_charge), .out_eoe(out_eoe)
    );

    // stimulus {eoe, addr, chip, raw}
    localparam logic [20:0] STIM [NSTIM] = '{
        {1'b0,6'd5,2'd0,12'd300},  {1'b1,6'd0,2'd0,12'd0},
        {1'b0,6'd20,2'd0,12'd110}, {1'b0,6'd21,2'd0,12'd150}, {1'b0,6'd22,2'd0,12'd300},
        {1'b0,6'd23,2'd0,12'd150}, {1'b0,6'd24,2'd0,12'd110}, {1'b1,6'd0,2'd0,12'd0},
        {1'b0,6'd30,2'd1,12'd100}, {1'b0,6'd31,2'd1,12'd150}, {1'b0,6'd32,2'd1,12'd75},
        {1'b0,6'd33,2'd1,12'd40},  {1'b1,6'd0,2'd0,12'd0},
        {1'b0,6'd40,2'd2,12'd200}, {1'b0,6'd42,2'd2,12'd160}, {1'b1,6'd0,2'd0,12'd0},
        {1'b0,6'd9,2'd0,12'd200},  {1'b0,6'd10,2'd0,12'd1000},{1'b0,6'd11,2'd0,12'd200},
        {1'b1,6'd0,2'd0,12'd0},
        {1'b0,6'd50,2'd1,12'd4095},{1'b1,6'd0,2'd0,12'd0},
        {1'b0,6'd1,2'd0,12'd150},  {1'b0,6'd2,2'd0,12'd200},  {1'b0,6'd3,2'd0,12'd400},
        {1'b0,6'd4,2'd0,12'd300},  {1'b0,6'd5,2'd0,12'd130},  {1'b1,6'd0,2'd0,12'd0},
        {1'b0,6'd12,2'd0,12'd200}, {1'b0,6'd13,2'd0,12'd200}, {1'b1,6'd0,2'd0,12'd0},
        {1'b0,6'd62,2'd0,12'd200}, {1'b0,6'd63,2'd0,12'd300}, {1'b0,6'd0,2'd0,12'd300},
        {1'b1,6'd0,2'd0,12'd0},
        {1'b0,6'd7,2'd0,12'd120},  {1'b1,6'd0,2'd0,12'd0}
    };

    // expected outputs {eoe, centroid, charge}
    localparam logic [26:0] EXP [NEXP] = '{
        {1'b0,10'd80,16'd200},   {1'b1,10'd0,16'd0},   // R2 single strip
        {1'b0,10'd352,16'd300},  {1'b1,10'd0,16'd0},   // R3 R6 symmetric, edge strips below thr
        {1'b0,10'd494,16'd350},  {1'b1,10'd0,16'd0},   // R2 clamp, R7 negative offset
        {1'b0,10'd640,16'd100},  {1'b0,10'd672,16'd80}, {1'b1,10'd0,16'd0}, // R4 gap, R8 flush
        {1'b0,10'd144,16'd100},  {1'b0,10'd176,16'd100}, {1'b1,10'd0,16'd0}, // R1 mask split
        {1'b0,10'd800,16'd4095}, {1'b1,10'd0,16'd0},   // R2 saturation
        {1'b0,10'd49,16'd680},   {1'b1,10'd0,16'd0},   // R6 R7 full window, R5 sum
        {1'b0,10'd200,16'd200},  {1'b1,10'd0,16'd0},   // R6 tie picks first
        {1'b0,10'd1003,16'd300}, {1'b0,10'd0,16'd200}, {1'b1,10'd0,16'd0}, // R4 no wrap
        {1'b1,10'd0,16'd0}                             // R3 amplitude equal to thr
    };

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && n_got < 64) begin got[n_got] = {1'b0, out_centroid, out_charge}; n_got++; end
            if (out_eoe && n_got < 64)   begin got[n_got] = {1'b1, 10'd0, 16'd0}; n_got++; end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] k, input logic [5:0] idx, input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = k; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [20:0] s);
        @(negedge clk);
        in_valid = 1'b1;
        {in_eoe, in_addr, in_chip, in_raw} = s;
        while (!in_ready) begin stalls++; @(negedge clk); end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0; in_eoe = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 out_valid", 32'(out_valid), 0);
        check("R10 out_eoe", 32'(out_eoe), 0);
        check("R10 in_ready", 32'(in_ready), 1);
        @(negedge clk) rst_n = 1'b1;

        // R10 default tables: ped 0, gain unity, threshold 0
        send({1'b0,6'd3,2'd1,12'd5});
        send({1'b1,6'd0,2'd0,12'd0});
        idle(6);
        check("R10 default count", 32'(n_got), 2);
        check("R10 default cluster", 32'(got[0]), 32'({1'b0,10'd48,16'd5}));
        check("R10 default eoe", 32'(got[1]), 32'({1'b1,10'd0,16'd0}));

        // R11 latency: closing sample accepted at an edge, cluster visible two edges later
        n_got = 0;
        send({1'b0,6'd8,2'd0,12'd9});
        send({1'b1,6'd0,2'd0,12'd0});
        @(negedge clk); in_valid = 1'b0;
        check("R11 before", 32'(out_valid), 0);
        @(negedge clk);
        check("R11 cluster", 32'(out_valid), 1);
        @(negedge clk);
        check("R8 eoe next", 32'(out_eoe), 1);
        idle(4);

        // configuration (R11-style map in R1/R2/R3)
        cfg_write(2'd3, 6'd0, 12'd20);
        cfg_write(2'd1, 6'd0, 12'd100);
        cfg_write(2'd1, 6'd1, 12'd50);
        cfg_write(2'd1, 6'd2, 12'd0);
        cfg_write(2'd2, 6'd0, 12'd256);
        cfg_write(2'd2, 6'd1, 12'd512);
        cfg_write(2'd2, 6'd2, 12'd128);
        cfg_write(2'd0, 6'd10, 12'd1);

        n_got = 0; stalls = 0;
        for (int i = 0; i < NSTIM; i++) send(STIM[i]);
        idle(10);

        check("R8 output count", 32'(n_got), NEXP);
        for (int i = 0; i < NEXP; i++)
            check($sformatf("R5/R6/R7 item %0d", i), 32'(got[i]), 32'(EXP[i]));
        check("R9 stall seen", 32'(stalls > 0), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule